// File: doc/BRIEF.md
# Selectable-Gate IF Frequency Counter

This block measures the frequency of an intermediate-frequency signal by counting its rising edges during a gate window of fixed, selectable length. Two IF inputs share one counter. A pair of control bits picks the counted input, or turns the second input into a plain digital port. Both inputs are synchronous to the reference clock and pass through a synchroniser and a rising-edge detector; no prescaler sits in front of the counter. The gate is timed by dividing the reference clock, whose frequency is a parameter. A 2-bit code selects a gate of 4, 8, 32 or 64 ms.

A one-cycle start pulse clears the count and opens the gate. When the gate closes, a done flag rises and stays high until the next start. The result is read serially. A rising read strobe loads the count into a shift register, and data-out shows the MSB at once. Each later rising edge of the read clock moves the next bit onto data-out. In port mode the readout is a single bit, the level of the second input, followed by zeros. Both the reference-clock rate and the counter width are parameters. The counter saturates at all ones and does not wrap.

Top module: `if_gate_counter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `done` and `dout` are 0.
- R2: A `start` high at a clock edge clears the count and opens the gate. `done` rises exactly G clock edges later, where G = ms × REF_HZ/1000. `gate_code` 2'b00 selects 4 ms, 2'b01 selects 8 ms, 2'b10 selects 32 ms and 2'b11 selects 64 ms. The code is captured at start.
- R3: `done` stays high until the next `start`, and is 0 from the edge at which that `start` is sampled.
- R4: With `b_is_if`=1 and `sel_b`=0, rising edges of `if_a` are counted and activity on `if_b` has no effect on the result.
- R5: With `b_is_if`=1 and `sel_b`=1, rising edges of `if_b` are counted and activity on `if_a` has no effect on the result.
- R6: Edges that arrive after the gate has closed leave the result unchanged.
- R7: The count saturates at all ones (2^CNT_W − 1) and does not wrap.
- R8: With `b_is_if`=0, the readout is the synchronised level of `if_b` in the MSB position (1 for high, 0 for low), with zeros in all other bits, whatever the value of `sel_b`.
- R9: When `rd_en` rises, the result is loaded and its MSB appears on `dout`. Each rising edge of `rd_clk` while `rd_en` stays high presents the next lower bit. After the LSB, `dout` reads 0.
- R10: While `rd_en` is low, `dout` is 0 and `rd_clk` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock of frequency REF_HZ |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse: clear count, open gate |
| sel_b | input | 1 | Counter select: 0 counts `if_a`, 1 counts `if_b` (in IF mode) |
| b_is_if | input | 1 | 1: `if_b` is an IF input; 0: `if_b` is a digital port |
| gate_code | input | 2 | Gate length code (4/8/32/64 ms) |
| if_a | input | 1 | First IF input |
| if_b | input | 1 | Second IF input, or digital port |
| rd_en | input | 1 | Read strobe; rising edge loads the result |
| rd_clk | input | 1 | Read clock; each rising edge shifts one bit |
| dout | output | 1 | Serial result, MSB first, registered |
| done | output | 1 | Gate-closed flag, registered |

## Verification
A table of gate runs drives counted pulse trains on both inputs at once, each with a different number of pulses. The value read back therefore shows which input the select bits routed to the counter, and shows that the other input leaked nothing in. The four gate codes are each measured as a start-to-done distance in cycles, which separates a wrong code mapping from an off-by-one in the gate timer. The runs also include an empty gate, pulses after the gate has closed, an overflowing pulse train, and port mode with the second input high and low under both values of the select bit. These separate a wrap from saturation, and a live count from a frozen one. A read past the LSB and `rd_clk` toggling with the strobe low show where the shift register stops.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

  typedef enum logic [1:0] {
    SRC_A    = 2'd0,
    SRC_B    = 2'd1,
    SRC_PORT = 2'd2
  } src_e;

  // Gate length in milliseconds for each 2-bit code.
  function automatic int unsigned gate_ms(input logic [1:0] code);
    case (code)
      2'b00:   return 4;
      2'b01:   return 8;
      2'b10:   return 32;
      default: return 64;
    endcase
  endfunction

  // Port mode overrides the counter-select bit.
  function automatic src_e pick_src(input logic b_is_if, input logic sel_b);
    if (!b_is_if)  return SRC_PORT;
    else if (sel_b) return SRC_B;
    else            return SRC_A;
  endfunction

endpackage

// File: rtl/ifc_sync.sv
module ifc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign level = chain[STAGES-1];
endmodule

// File: rtl/ifc_gate_timer.sv
module ifc_gate_timer #(
  parameter int TICKS_PER_MS = 100000,
  parameter int TW           = 23
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] code,
  output logic       gate_on,
  output logic       done
);
  logic [TW-1:0] tcnt;
  logic [TW-1:0] limit;

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt    <= '0;
      limit   <= '0;
      gate_on <= 1'b0;
      done    <= 1'b0;
    end else if (start) begin
      tcnt    <= '0;
      limit   <= TW'(ifc_pkg::gate_ms(code) * TICKS_PER_MS - 1);
      gate_on <= 1'b1;
      done    <= 1'b0;
    end else if (gate_on) begin
      if (tcnt == limit) begin
        gate_on <= 1'b0;
        done    <= 1'b1;
      end else begin
        tcnt <= tcnt + TW'(1);
      end
    end
  end
endmodule

// File: rtl/ifc_sat_counter.sv
module ifc_sat_counter #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)              cnt <= '0;
    else if (en && (cnt != '1))  cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/ifc_serial_out.sv
module ifc_serial_out #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_en,
  input  logic         rd_clk,
  input  logic [W-1:0] word,
  output logic         dout
);
  logic [W-1:0] sh;
  logic         rd_en_q;
  logic         rd_clk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      rd_en_q  <= 1'b0;
      rd_clk_q <= 1'b0;
      dout     <= 1'b0;
    end else begin
      rd_en_q  <= rd_en;
      rd_clk_q <= rd_clk;
      if (!rd_en) begin
        dout <= 1'b0;
      end else if (!rd_en_q) begin
        sh   <= word;
        dout <= word[W-1];
      end else if (rd_clk && !rd_clk_q) begin
        sh   <= {sh[W-2:0], 1'b0};
        dout <= sh[W-2];
      end
    end
  end
endmodule

// File: rtl/if_gate_counter.sv
module if_gate_counter #(
  parameter int REF_HZ      = 100_000_000,
  parameter int CNT_W       = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       sel_b,
  input  logic       b_is_if,
  input  logic [1:0] gate_code,
  input  logic       if_a,
  input  logic       if_b,
  input  logic       rd_en,
  input  logic       rd_clk,
  output logic       dout,
  output logic       done
);
  import ifc_pkg::*;

  localparam int TICKS_PER_MS = REF_HZ / 1000;
  localparam int TW           = $clog2(64 * TICKS_PER_MS + 1);

  logic [1:0]       raw;
  logic [1:0]       lvl;
  logic [1:0]       lvl_q;
  logic [1:0]       rise;
  logic             gate_on;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] word;
  src_e             src_q;

  assign raw = {if_b, if_a};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_in
      ifc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   (raw[g]),
        .level (lvl[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
      src_q <= SRC_A;
    end else begin
      lvl_q <= lvl;
      if (start) src_q <= pick_src(b_is_if, sel_b);
    end
  end

  assign rise = lvl & ~lvl_q;

  always_comb begin
    case (src_q)
      SRC_A:   cnt_en = gate_on & rise[0];
      SRC_B:   cnt_en = gate_on & rise[1];
      default: cnt_en = 1'b0;
    endcase
  end

  ifc_gate_timer #(.TICKS_PER_MS(TICKS_PER_MS), .TW(TW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .code    (gate_code),
    .gate_on (gate_on),
    .done    (done)
  );

  ifc_sat_counter #(.W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (start),
    .en  (cnt_en),
    .cnt (cnt)
  );

  // Port mode is decided from the live control bits at readout time.
  assign word = (pick_src(b_is_if, sel_b) == SRC_PORT) ?
                {lvl[1], {(CNT_W-1){1'b0}}} : cnt;

  ifc_serial_out #(.W(CNT_W)) u_ser (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .rd_clk (rd_clk),
    .word   (word),
    .dout   (dout)
  );
endmodule

// File: rtl/ifc_checker.sv
module ifc_checker #(
  parameter int W = 20
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         done,
  input logic         gate_on,
  input logic [W-1:0] cnt,
  input logic         rd_en,
  input logic         dout
);
  AST_GATE_CLOSE_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_on) |-> done);                                   // R2
  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
    start |=> !done);                                           // R3
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);                                 // R3
  AST_FROZEN_AFTER_GATE: assert property (@(posedge clk) disable iff (rst)
    (!gate_on && !start) |=> $stable(cnt));                     // R6
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    ((cnt == '1) && !start) |=> (cnt == '1));                   // R7
  AST_DOUT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !dout);                                          // R10
endmodule

bind if_gate_counter ifc_checker #(.W(CNT_W)) u_ifc_checker (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .done    (done),
  .gate_on (gate_on),
  .cnt     (cnt),
  .rd_en   (rd_en),
  .dout    (dout)
);

// File: tb/test_if_gate_counter.sv
module test_if_gate_counter;
  localparam int REF_HZ = 10_000;  // 10 cycles per ms
  localparam int W      = 8;
  localparam int TPM    = REF_HZ / 1000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0, sel_b = 1'b0, b_is_if = 1'b1;
  logic [1:0] gate_code = 2'b00;
  logic       if_a = 1'b0, if_b = 1'b0, rd_en = 1'b0, rd_clk = 1'b0;
  logic       dout, done;
  int         checks = 0, errors = 0;

  always #5 clk = ~clk;

  if_gate_counter #(.REF_HZ(REF_HZ), .CNT_W(W)) i_if_gate_counter (
    .clk(clk), .rst(rst), .start(start), .sel_b(sel_b), .b_is_if(b_is_if),
    .gate_code(gate_code), .if_a(if_a), .if_b(if_b), .rd_en(rd_en),
    .rd_clk(rd_clk), .dout(dout), .done(done)
  );

  // {b_is_if, sel_b, gate_code, pulses_a[9:0], pulses_b[9:0], expected[7:0]}
  localparam logic [31:0] VEC [6] = '{
    {1'b1, 1'b0, 2'd0, 10'd7,   10'd3,   8'd7},
    {1'b1, 1'b1, 2'd0, 10'd5,   10'd12,  8'd12},
    {1'b1, 1'b0, 2'd1, 10'd30,  10'd2,   8'd30},
    {1'b1, 1'b1, 2'd2, 10'd1,   10'd150, 8'd150},
    {1'b1, 1'b0, 2'd3, 10'd200, 10'd0,   8'd200},
    {1'b1, 1'b1, 2'd0, 10'd0,   10'd0,   8'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ms_of(input logic [1:0] c);
    case (c)
      2'b00: return 4;
      2'b01: return 8;
      2'b10: return 32;
      default: return 64;
    endcase
  endfunction

  task automatic run_gate(input logic b, input logic s, input logic [1:0] c,
                          input int na, input int nb, output int dur);
    int n;
    @(negedge clk);
    b_is_if = b; sel_b = s; gate_code = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
      if_a = (n >= 5) && (n < 5 + 2*na) && ((n - 5) % 2 == 0);
      if_b = (n >= 5) && (n < 5 + 2*nb) && ((n - 5) % 2 == 0);
    end
    if_a = 1'b0; if_b = 1'b0;
    dur = n;
  endtask

  task automatic read_word(output logic [W-1:0] v, output logic ext);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); v[W-1] = dout;
    for (int i = W-2; i >= 0; i--) begin
      rd_clk = 1'b1; @(negedge clk); v[i] = dout;
      rd_clk = 1'b0; @(negedge clk);
    end
    rd_clk = 1'b1; @(negedge clk); ext = dout;
    rd_clk = 1'b0; @(negedge clk);
    rd_en = 1'b0; @(negedge clk);
    chk(dout == 1'b0, "R10 dout after strobe", dout, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    logic ext;
    int dur;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done in reset", done, 0);
    chk(dout == 1'b0, "R1 dout in reset", dout, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && dout == 1'b0, "R1 after reset", {done, dout}, 0);

    // Vector table: R2 gate length, R4/R5 source select, R9 readout
    for (int k = 0; k < 6; k++) begin
      run_gate(VEC[k][31], VEC[k][30], VEC[k][29:28],
               int'(VEC[k][27:18]), int'(VEC[k][17:8]), dur);
      chk(dur == ms_of(VEC[k][29:28]) * TPM, "R2 gate length", dur,
          ms_of(VEC[k][29:28]) * TPM);
      read_word(v, ext);
      chk(v == VEC[k][7:0], VEC[k][30] ? "R5 count of if_b" : "R4 count of if_a",
          v, VEC[k][7:0]);
      chk(ext == 1'b0, "R9 bit after LSB", ext, 0);
    end

    // R6 / R3: pulses after gate close, done held
    run_gate(1'b1, 1'b0, 2'b00, 4, 0, dur);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); if_a = 1'b1;
      @(negedge clk); if_a = 1'b0;
    end
    repeat (4) @(negedge clk);
    chk(done == 1'b1, "R3 done held", done, 1);
    read_word(v, ext);
    chk(v == 8'd4, "R6 late edges ignored", v, 4);

    // R3: start clears done
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done == 1'b0, "R3 start clears done", done, 0);
    while (!done) @(negedge clk);

    // R7: saturation at 64 ms gate
    run_gate(1'b1, 1'b0, 2'b11, 300, 0, dur);
    read_word(v, ext);
    chk(v == 8'hFF, "R7 saturation", v, 255);

    // R8: port mode, sel_b ignored
    b_is_if = 1'b0; sel_b = 1'b1; if_b = 1'b1;
    repeat (4) @(negedge clk);
    read_word(v, ext);
    chk(v == 8'h80, "R8 port high sel_b=1", v, 128);
    sel_b = 1'b0;
    read_word(v, ext);
    chk(v == 8'h80, "R8 port high sel_b=0", v, 128);
    if_b = 1'b0;
    repeat (4) @(negedge clk);
    read_word(v, ext);
    chk(v == 8'h00, "R8 port low", v, 0);

    // R10: rd_clk toggling with strobe low
    for (int i = 0; i < 6; i++) begin
      rd_clk = ~rd_clk;
      @(negedge clk);
      chk(dout == 1'b0, "R10 dout idle", dout, 0);
    end
    rd_clk = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule